// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the state that a processor's memory pipeline needs for load-linked / store-conditional atomic sequences. When a load-linked operation is accepted, it captures the upper part of the physical address (bits 35 down to 4) into a link register and sets a reservation bit. A later store-conditional may write memory only while that reservation bit is still set. The old value of the bit is returned as the result that goes back into the destination register, and the bit is then cleared. An external invalidate input and an exception-return input both cancel the reservation. Only the invalidate input represents coherence traffic.

The monitor also holds a pending-synchronisation flag. Every accepted load-linked or store-conditional sets it. The next memory operation that finds it set is told to synchronise first, and that clears it. The block checks natural alignment for word and doubleword forms and rejects doubleword forms when the core is not in 64-bit mode. The pipeline presents one operation per cycle on a strobe. The response for that operation appears one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: During and directly after reset, resvValid, syncPending, linkAddr and all response outputs are 0.
- R2: An accepted load-linked (opKind 1 = word, 2 = doubleword) sets resvValid and loads linkAddr with physAddr[35:4]. Both are visible on the cycle after the strobe.
- R3: A store-conditional (opKind 3 = word, 4 = doubleword) that finds resvValid set returns respStore = 1 and respResult = 1, and it clears resvValid.
- R4: A store-conditional that finds resvValid clear returns respStore = 0 and respResult = 0.
- R5: Every accepted load-linked or store-conditional leaves syncPending set. A plain memory operation (opKind 0, or any of 5 to 7) never sets it.
- R6: Any operation that is not rejected as reserved, and that finds syncPending set, returns respSync = 1. After it, syncPending is 0 unless the operation is itself a load-linked or store-conditional.
- R7: A word form with physAddr[1:0] != 0, or a doubleword form with physAddr[2:0] != 0, returns respAddrErr = 1. It leaves resvValid and linkAddr unchanged and does not store. The synchronisation it triggers still takes place.
- R8: A doubleword form (opKind 2 or 4) while mode64 = 0 returns respRsvdInstr = 1. It changes none of resvValid, linkAddr or syncPending, and it does not synchronise.
- R9: An invalidate or excReturn pulse clears resvValid on the next cycle and leaves linkAddr unchanged.
- R10: A load-linked accepted in the same cycle as invalidate or excReturn leaves resvValid set.
- R11: A store-conditional in the same cycle as an invalidate is judged on the reservation held before that edge. resvValid is cleared afterwards.
- R12: respValid is 1 exactly on the cycle after an opValid strobe, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Memory operation strobe |
| opKind | input | 3 | Operation code (0 plain, 1 LL word, 2 LL dword, 3 SC word, 4 SC dword) |
| physAddr | input | 36 | Physical address of the operation |
| mode64 | input | 1 | Core is in 64-bit mode; doubleword forms are allowed |
| invalidate | input | 1 | External reservation cancel |
| excReturn | input | 1 | Exception return; cancels the reservation |
| respValid | output | 1 | Response for the previous cycle's operation |
| respStore | output | 1 | Store-conditional may write memory |
| respResult | output | 64 | Value returned to the destination register (0 or 1) |
| respSync | output | 1 | Synchronise before this operation proceeds |
| respAddrErr | output | 1 | Alignment fault |
| respRsvdInstr | output | 1 | Doubleword form outside 64-bit mode |
| resvValid | output | 1 | Reservation bit |
| linkAddr | output | 32 | Recorded physical address bits 35:4 |
| syncPending | output | 1 | Pending-synchronisation flag |

## Verification
Every response and every state change has a latency of exactly one register. An operation or cancel pulse sampled at one rising edge is therefore reflected at the following falling edge, and it stays visible until the next rising edge. The bench drives stimulus a quarter period after each rising edge. It steps its behavioural model on the rising edge, using the same inputs the design samples there, and compares all outputs at the falling edge. Each comparison carries the requirement tag of the operation that produced it, so the same-cycle races in R10 and R11 are judged on the edge where both events land.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  // Operation encoding presented on opKind
  localparam logic [2:0] KIND_PLAIN = 3'd0;
  localparam logic [2:0] KIND_LLW   = 3'd1;
  localparam logic [2:0] KIND_LLD   = 3'd2;
  localparam logic [2:0] KIND_SCW   = 3'd3;
  localparam logic [2:0] KIND_SCD   = 3'd4;

  // Alignment widths (log2 of access size in bytes)
  localparam int WORD_LG = 2;
  localparam int DBL_LG  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic respValid;  // an operation was presented
    logic doSync;     // synchronisation performed for this operation
    logic addrErr;    // alignment fault
    logic rsvdInstr;  // doubleword form outside 64-bit mode
    logic loadLink;   // accepted load-linked
    logic scAttempt;  // accepted store-conditional
    logic dropResv;   // cancel request from outside
  } ctrlStrb_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [DBL_LG-1:0] addrLow,
  input  logic              mode64,
  input  logic              invalidate,
  input  logic              excReturn,
  input  logic              syncQ,
  output ctrlStrb_t         strb
);

  logic isLink, isCond, isDbl, misAligned;

  always_comb begin
    isLink = 1'b0;
    isCond = 1'b0;
    isDbl  = 1'b0;
    case (opKind)
      KIND_LLW: isLink = 1'b1;
      KIND_LLD: begin isLink = 1'b1; isDbl = 1'b1; end
      KIND_SCW: isCond = 1'b1;
      KIND_SCD: begin isCond = 1'b1; isDbl = 1'b1; end
      default:  ;
    endcase
  end

  // Alignment depends on the access size of the form
  always_comb begin
    if (isDbl) misAligned = |addrLow[DBL_LG-1:0];
    else       misAligned = |addrLow[WORD_LG-1:0];
  end

  // Order matters: mode check, then synchronisation, then alignment
  always_comb begin
    strb           = '0;
    strb.respValid = opValid;
    strb.dropResv  = invalidate | excReturn;
    if (opValid) begin
      if (isDbl && !mode64) begin
        strb.rsvdInstr = 1'b1;
      end else begin
        strb.doSync = syncQ;
        if ((isLink || isCond) && misAligned) begin
          strb.addrErr = 1'b1;
        end else begin
          strb.loadLink  = isLink;
          strb.scAttempt = isCond;
        end
      end
    end
  end

  // R7 / R8: at most one outcome class per operation
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.addrErr, strb.rsvdInstr, strb.loadLink | strb.scAttempt}));

  // R8: a rejected doubleword form never synchronises
  p_rsvd_no_sync_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rsvdInstr |-> !strb.doSync);

endmodule

// File: rtl/llsc_dpath.sv
module llsc_dpath
  import llsc_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int LINK_LO = 4,
  parameter int DATA_W  = 64,
  localparam int LINK_W = PA_W - LINK_LO
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [PA_W-1:0]   physAddr,
  output logic              resvValid,
  output logic [LINK_W-1:0] linkAddr,
  output logic              syncPending,
  output logic              respValid,
  output logic              respStore,
  output logic [DATA_W-1:0] respResult,
  output logic              respSync,
  output logic              respAddrErr,
  output logic              respRsvdInstr
);

  logic              resvQ, syncQ, okQ;
  logic [LINK_W-1:0] linkQ;

  // Reservation bit: a load-linked wins over any cancel in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                                resvQ <= 1'b0;
    else if (strb.loadLink)                   resvQ <= 1'b1;
    else if (strb.scAttempt || strb.dropResv) resvQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              linkQ <= '0;
    else if (strb.loadLink) linkQ <= physAddr[PA_W-1:LINK_LO];
  end

  // Synchronisation flag: armed by LL/SC, consumed by a sync
  always_ff @(posedge clk) begin
    if (!rstN)                                 syncQ <= 1'b0;
    else if (strb.loadLink || strb.scAttempt)  syncQ <= 1'b1;
    else if (strb.doSync)                      syncQ <= 1'b0;
  end

  // Response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respSync      <= 1'b0;
      respAddrErr   <= 1'b0;
      respRsvdInstr <= 1'b0;
      respStore     <= 1'b0;
      okQ           <= 1'b0;
    end else begin
      respValid     <= strb.respValid;
      respSync      <= strb.doSync;
      respAddrErr   <= strb.addrErr;
      respRsvdInstr <= strb.rsvdInstr;
      respStore     <= strb.scAttempt & resvQ;
      okQ           <= strb.scAttempt & resvQ;
    end
  end

  generate
    if (DATA_W > 1) begin : g_pad
      assign respResult = {{(DATA_W-1){1'b0}}, okQ};
    end else begin : g_bit
      assign respResult = okQ;
    end
  endgenerate

  assign resvValid   = resvQ;
  assign linkAddr    = linkQ;
  assign syncPending = syncQ;

  // R2: an accepted load-linked always leaves a reservation
  p_link_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLink |=> resvValid);

  // R4: no store without a reservation
  p_no_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scAttempt && !resvQ) |=> !respStore);

  // R5: load-linked and store-conditional arm the sync flag
  p_sync_armed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLink || strb.scAttempt) |=> syncPending);

  // R9: cancel without a competing load-linked clears the reservation
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dropResv && !strb.loadLink) |=> !resvValid);

  // R9: link address only moves on a load-linked
  p_link_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadLink |=> $stable(linkAddr));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int LINK_LO = 4,
  parameter int DATA_W  = 64,
  localparam int LINK_W = PA_W - LINK_LO
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [PA_W-1:0]   physAddr,
  input  logic              mode64,
  input  logic              invalidate,
  input  logic              excReturn,
  output logic              respValid,
  output logic              respStore,
  output logic [DATA_W-1:0] respResult,
  output logic              respSync,
  output logic              respAddrErr,
  output logic              respRsvdInstr,
  output logic              resvValid,
  output logic [LINK_W-1:0] linkAddr,
  output logic              syncPending
);

  ctrlStrb_t strb;

  llsc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opKind     (opKind),
    .addrLow    (physAddr[DBL_LG-1:0]),
    .mode64     (mode64),
    .invalidate (invalidate),
    .excReturn  (excReturn),
    .syncQ      (syncPending),
    .strb       (strb)
  );

  llsc_dpath #(.PA_W(PA_W), .LINK_LO(LINK_LO), .DATA_W(DATA_W)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .physAddr      (physAddr),
    .resvValid     (resvValid),
    .linkAddr      (linkAddr),
    .syncPending   (syncPending),
    .respValid     (respValid),
    .respStore     (respStore),
    .respResult    (respResult),
    .respSync      (respSync),
    .respAddrErr   (respAddrErr),
    .respRsvdInstr (respRsvdInstr)
  );

  // R12: one response per strobe, one cycle later
  p_resp_follows_r12: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> respValid);
  p_resp_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !respValid);

  // R8: a rejected doubleword form leaves link and sync state alone
  p_rsvd_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !mode64 && (opKind == KIND_LLD || opKind == KIND_SCD))
      |=> ($stable(linkAddr) && $stable(syncPending)));

  // R3: a store is always reported as success in the result
  p_store_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    respStore |-> (respResult == DATA_W'(1)));

endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [35:0] physAddr = '0;
  logic        mode64 = 1'b1;
  logic        invalidate = 1'b0;
  logic        excReturn = 1'b0;

  logic        respValid, respStore, respSync, respAddrErr, respRsvdInstr;
  logic [63:0] respResult;
  logic        resvValid, syncPending;
  logic [31:0] linkAddr;

  always #10 clk = ~clk;  // 50 MHz

  llsc_monitor dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .physAddr(physAddr), .mode64(mode64), .invalidate(invalidate),
    .excReturn(excReturn), .respValid(respValid), .respStore(respStore),
    .respResult(respResult), .respSync(respSync), .respAddrErr(respAddrErr),
    .respRsvdInstr(respRsvdInstr), .resvValid(resvValid),
    .linkAddr(linkAddr), .syncPending(syncPending)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string curTag = "R12";
  string mTag = "R1";

  // Behavioural reference state
  bit        mResv, mSync, mRv, mSt, mSy, mAe, mRi;
  bit [31:0] mLink;
  bit [63:0] mRes;

  always @(posedge clk) begin
    if (!rstN) begin
      mResv = 0; mSync = 0; mLink = 0;
      mRv = 0; mSt = 0; mSy = 0; mAe = 0; mRi = 0; mRes = 0;
      mTag = "R1";
    end else begin
      bit ll, sc, dbl, bad, nResv, nSync;
      mTag = curTag;
      ll  = opValid && (opKind == 3'd1 || opKind == 3'd2);
      sc  = opValid && (opKind == 3'd3 || opKind == 3'd4);
      dbl = (opKind == 3'd2 || opKind == 3'd4);
      nResv = mResv; nSync = mSync;
      mRv = opValid; mSt = 0; mSy = 0; mAe = 0; mRi = 0; mRes = 0;
      if (invalidate || excReturn) nResv = 0;
      if (opValid) begin
        if ((ll || sc) && dbl && !mode64) mRi = 1;
        else begin
          mSy = mSync;
          if (mSync) nSync = 0;
          bad = (ll || sc) && (dbl ? (physAddr[2:0] != 0) : (physAddr[1:0] != 0));
          if (bad) mAe = 1;
          else if (ll) begin
            mLink = physAddr[35:4]; nResv = 1; nSync = 1;
          end else if (sc) begin
            mSt = mResv; mRes = {63'd0, mResv}; nResv = 0; nSync = 1;
          end
        end
      end
      mResv = nResv; mSync = nSync;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if ({respValid, respStore, respSync, respAddrErr, respRsvdInstr, resvValid, syncPending}
          !== {mRv, mSt, mSy, mAe, mRi, mResv, mSync}
          || respResult !== mRes || linkAddr !== mLink) begin
        fails++;
        $display("FAIL %s: got v%b st%b sy%b ae%b ri%b rsv%b sp%b res%0h link%h exp v%b st%b sy%b ae%b ri%b rsv%b sp%b res%0h link%h",
                 mTag, respValid, respStore, respSync, respAddrErr, respRsvdInstr,
                 resvValid, syncPending, respResult, linkAddr,
                 mRv, mSt, mSy, mAe, mRi, mResv, mSync, mRes, mLink);
      end
    end
  end

  task automatic step(input string tag, input bit v, input logic [2:0] k,
                      input logic [35:0] a, input bit m64, input bit inv, input bit exr);
    @(posedge clk); #5;
    curTag = tag; opValid = v; opKind = k; physAddr = a;
    mode64 = m64; invalidate = inv; excReturn = exr;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    step("R12", 0, 3'd0, 36'h0, 1, 0, 0);
    step("R2",  1, 3'd1, 36'h9_1234_5670, 1, 0, 0);   // LL word
    step("R6",  1, 3'd0, 36'h0_0000_0003, 1, 0, 0);   // plain op consumes sync
    step("R3",  1, 3'd3, 36'h9_1234_5670, 1, 0, 0);   // SC success
    step("R4",  1, 3'd3, 36'h9_1234_5670, 1, 0, 0);   // SC fails
    step("R5",  1, 3'd0, 36'h0_0000_0100, 1, 0, 0);
    step("R5",  1, 3'd7, 36'h0_0000_0101, 1, 0, 0);   // code 7 acts as plain
    step("R2",  1, 3'd2, 36'hA_BCDE_F008, 1, 0, 0);   // LL dword
    step("R9",  0, 3'd0, 36'h0, 1, 1, 0);             // invalidate
    step("R4",  1, 3'd4, 36'hA_BCDE_F008, 1, 0, 0);   // SC dword fails
    step("R10", 1, 3'd1, 36'h1_1111_1110, 1, 1, 0);   // LL wins over invalidate
    step("R10", 1, 3'd1, 36'h2_2222_2220, 1, 0, 1);   // LL wins over exc return
    step("R11", 1, 3'd3, 36'h2_2222_2220, 1, 1, 0);   // SC with invalidate, succeeds
    step("R12", 0, 3'd0, 36'h0, 1, 0, 0);
    step("R2",  1, 3'd1, 36'h3_0000_0040, 1, 0, 0);
    step("R9",  0, 3'd0, 36'h0, 1, 0, 1);             // exception return
    step("R2",  1, 3'd1, 36'h4_0000_0080, 1, 0, 0);
    step("R7",  1, 3'd1, 36'h5_0000_0002, 1, 0, 0);   // misaligned LL word
    step("R7",  1, 3'd4, 36'h4_0000_0084, 1, 0, 0);   // SC dword on word boundary
    step("R7",  1, 3'd3, 36'h4_0000_0081, 1, 0, 0);   // misaligned SC word
    step("R3",  1, 3'd3, 36'h4_0000_0080, 1, 0, 0);
    step("R8",  1, 3'd2, 36'h6_0000_0000, 0, 0, 0);   // LL dword in 32-bit mode
    step("R8",  1, 3'd4, 36'h6_0000_0000, 0, 0, 0);
    step("R8",  1, 3'd1, 36'h7_0000_0010, 0, 0, 0);   // word form still fine
    step("R8",  1, 3'd2, 36'h8_0000_0010, 0, 0, 0);
    step("R3",  1, 3'd3, 36'h7_0000_0010, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [35:0] ra;
      ra = {4'($urandom), 32'($urandom)};
      if ($urandom_range(0, 2) != 0) ra[2:0] = 3'd0;
      step("R12", 1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), ra,
           1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 9) == 0));
    end
    step("R12", 0, 3'd0, 36'h0, 1, 0, 0);
    @(posedge clk); @(negedge clk); #1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete, exp completion");
      finishRun();
    end
  end

endmodule